// File: doc/BRIEF.md
# MII Receive Frame Delimiter

This block sits on the 4-bit receive side of a media-independent interface. It watches the nibble bus while the data-valid line is high and looks for a run of preamble nibbles followed by the start-of-frame delimiter. Once the delimiter has been seen, it joins each following pair of nibbles into one byte and presents the bytes as a stream. The stream marks the first byte and carries a per-byte error flag.

When data-valid falls, the block raises a one-cycle end pulse. With that pulse it reports the byte count of the frame and flags for runt, oversize, odd-nibble alignment, line error and dropped frames. The preamble may be left out entirely. If preamble nibbles are present, each of them must be correct, or the whole burst is dropped and produces no bytes. Address filtering, CRC checking and buffering belong to blocks further down the receive path.

Top module: `mii_rx_framer`

## Requirements
- R1: After reset, and before any burst arrives, byte_valid_o, byte_sof_o, byte_err_o and eof_o are all low.
- R2: After the delimiter, each pair of nibbles becomes one byte on byte_o. The first nibble supplies bits 3..0 and the second supplies bits 7..4. The byte is valid in the cycle after the second nibble is sampled, and two bytes are never valid in adjacent cycles.
- R3: On rxd_i a preamble nibble is 4'h5. The delimiter is 4'h5 followed by 4'hD. A burst that starts with the bare delimiter 5,D and has no further preamble is accepted (stat_drop_o = 0).
- R4: While the block is waiting for the delimiter, a nibble other than 4'h5 drops the frame. This includes 4'hD as the very first nibble. A dropped frame emits no bytes and reports stat_drop_o = 1 with stat_len_o = 0.
- R5: Once a frame has been dropped, every remaining nibble of the burst is ignored until rx_dv_i goes low, even if a valid delimiter appears later in the burst.
- R6: byte_sof_o is high together with the first byte of each frame and with no other byte.
- R7: eof_o pulses for one cycle, in the cycle after rx_dv_i is first sampled low following a burst. It never coincides with byte_valid_o. At that pulse, stat_len_o equals the number of bytes emitted.
- R8: stat_runt_o is set when an accepted frame has fewer than 64 bytes. A 64-byte frame is not a runt.
- R9: stat_long_o is set when an accepted frame has more than 1518 bytes. A 1518-byte frame is not oversize, and runt and oversize are never set together.
- R10: If rx_dv_i falls after an odd number of data nibbles, stat_align_o is set and the half byte is discarded. No extra byte is emitted and the count is not incremented.
- R11: If rx_er_i is high while rx_dv_i is high in an accepted frame, stat_err_o is set at the end pulse. byte_err_o is high on every byte emitted from that point on.
- R12: If rx_dv_i falls while the block is still inside the preamble, the burst is reported as dropped (stat_drop_o = 1, stat_len_o = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 4 | Receive nibble |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive line error |
| byte_o | output | 8 | Assembled frame byte |
| byte_valid_o | output | 1 | byte_o holds a new byte this cycle |
| byte_sof_o | output | 1 | First byte of the frame |
| byte_err_o | output | 1 | Frame has seen a line error so far |
| eof_o | output | 1 | End-of-burst pulse; status outputs valid |
| stat_len_o | output | LEN_W | Byte count of the frame (saturating) |
| stat_runt_o | output | 1 | Frame shorter than the minimum |
| stat_long_o | output | 1 | Frame longer than the maximum |
| stat_align_o | output | 1 | Odd nibble count; half byte discarded |
| stat_err_o | output | 1 | Line error seen during the frame |
| stat_drop_o | output | 1 | Bad or truncated preamble; frame dropped |

## Verification
The assertions assume that rx_dv_i stays low for at least one sampled cycle between bursts, so that every burst produces exactly one end pulse. They also assume that rxd_i and rx_er_i are stable around the rising edge. The stimulus changes inputs only on the falling clock edge and leaves two or more idle cycles after every burst. The spacing and delimiter properties further rely on the design never leaving the dropped state while rx_dv_i is high, and the stimulus includes bursts that place a valid delimiter after a drop to exercise that case.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_DROP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mii_rx_sync.sv
module mii_rx_sync
  import mii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] rxd_i,
  input  logic       rx_dv_i,
  output logic       pay_nib_o,
  output logic       frame_end_o,
  output logic       drop_end_o,
  output logic       in_drop_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rx_dv_i) state_d = (rxd_i == PRE_NIB) ? ST_PRE : ST_DROP;
      ST_PRE: begin
        if (!rx_dv_i)              state_d = ST_IDLE;
        else if (rxd_i == SFD_NIB) state_d = ST_DATA;
        else if (rxd_i != PRE_NIB) state_d = ST_DROP;
      end
      ST_DATA: if (!rx_dv_i) state_d = ST_IDLE;
      ST_DROP: if (!rx_dv_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign pay_nib_o   = rx_dv_i && (state_q == ST_DATA);
  assign frame_end_o = !rx_dv_i && (state_q != ST_IDLE);
  assign drop_end_o  = frame_end_o && (state_q != ST_DATA);
  assign in_drop_o   = (state_q == ST_DROP);

  AST_DROP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) && rx_dv_i |=> (state_q == ST_DROP)); // R5
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/mii_rx_pack.sv
module mii_rx_pack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pay_nib_i,
  input  logic [3:0] nib_i,
  input  logic       err_i,
  output logic       byte_done_o,
  output logic       half_o,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_sof_o,
  output logic       byte_err_o
);
  logic       phase_q, first_q;
  logic [3:0] lo_q;

  assign byte_done_o = pay_nib_i && phase_q;
  assign half_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= 1'b0;
      first_q      <= 1'b1;
      lo_q         <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      byte_sof_o   <= 1'b0;
      byte_err_o   <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      byte_sof_o   <= 1'b0;
      if (!pay_nib_i) begin
        phase_q <= 1'b0;
        first_q <= 1'b1;
      end else if (!phase_q) begin
        lo_q    <= nib_i;
        phase_q <= 1'b1;
      end else begin
        byte_o       <= {nib_i, lo_q};
        byte_valid_o <= 1'b1;
        byte_sof_o   <= first_q;
        byte_err_o   <= err_i;
        first_q      <= 1'b0;
        phase_q      <= 1'b0;
      end
    end
  end

  AST_BYTE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R2
endmodule

// File: rtl/mii_rx_stat.sv
module mii_rx_stat #(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned LEN_W   = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic             rx_er_i,
  input  logic             in_drop_i,
  input  logic             byte_done_i,
  input  logic             half_i,
  input  logic             frame_end_i,
  input  logic             drop_end_i,
  output logic             err_now_o,
  output logic             eof_o,
  output logic [LEN_W-1:0] stat_len_o,
  output logic             stat_runt_o,
  output logic             stat_long_o,
  output logic             stat_align_o,
  output logic             stat_err_o,
  output logic             stat_drop_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] MIN_C   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_C   = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] cnt_q;
  logic             err_q;

  assign err_now_o = err_q || (rx_dv_i && rx_er_i && !in_drop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      err_q        <= 1'b0;
      eof_o        <= 1'b0;
      stat_len_o   <= '0;
      stat_runt_o  <= 1'b0;
      stat_long_o  <= 1'b0;
      stat_align_o <= 1'b0;
      stat_err_o   <= 1'b0;
      stat_drop_o  <= 1'b0;
    end else begin
      eof_o <= frame_end_i;
      if (frame_end_i) begin
        stat_len_o   <= drop_end_i ? '0 : cnt_q;
        stat_drop_o  <= drop_end_i;
        stat_runt_o  <= !drop_end_i && (cnt_q < MIN_C);
        stat_long_o  <= !drop_end_i && (cnt_q > MAX_C);
        stat_align_o <= !drop_end_i && half_i;
        stat_err_o   <= !drop_end_i && err_q;
        cnt_q        <= '0;
        err_q        <= 1'b0;
      end else begin
        if (byte_done_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (rx_dv_i && rx_er_i && !in_drop_i) err_q <= 1'b1;
      end
    end
  end

  AST_RUNT_LONG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !(stat_runt_o && stat_long_o)); // R9
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer #(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       rxd_i,
  input  logic             rx_dv_i,
  input  logic             rx_er_i,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o,
  output logic             byte_sof_o,
  output logic             byte_err_o,
  output logic             eof_o,
  output logic [LEN_W-1:0] stat_len_o,
  output logic             stat_runt_o,
  output logic             stat_long_o,
  output logic             stat_align_o,
  output logic             stat_err_o,
  output logic             stat_drop_o
);
  logic pay_nib, frame_end, drop_end, in_drop;
  logic byte_done, half, err_now;

  mii_rx_sync u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rxd_i       (rxd_i),
    .rx_dv_i     (rx_dv_i),
    .pay_nib_o   (pay_nib),
    .frame_end_o (frame_end),
    .drop_end_o  (drop_end),
    .in_drop_o   (in_drop)
  );

  mii_rx_pack u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pay_nib_i    (pay_nib),
    .nib_i        (rxd_i),
    .err_i        (err_now),
    .byte_done_o  (byte_done),
    .half_o       (half),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_sof_o   (byte_sof_o),
    .byte_err_o   (byte_err_o)
  );

  mii_rx_stat #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_dv_i      (rx_dv_i),
    .rx_er_i      (rx_er_i),
    .in_drop_i    (in_drop),
    .byte_done_i  (byte_done),
    .half_i       (half),
    .frame_end_i  (frame_end),
    .drop_end_i   (drop_end),
    .err_now_o    (err_now),
    .eof_o        (eof_o),
    .stat_len_o   (stat_len_o),
    .stat_runt_o  (stat_runt_o),
    .stat_long_o  (stat_long_o),
    .stat_align_o (stat_align_o),
    .stat_err_o   (stat_err_o),
    .stat_drop_o  (stat_drop_o)
  );

  AST_EOF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !byte_valid_o); // R7
  AST_SOF_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_sof_o |-> byte_valid_o); // R6
  AST_DROP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o && stat_drop_o |-> (stat_len_o == '0) && !stat_runt_o && !stat_align_o); // R4
endmodule

// File: tb/tb_mii_rx_framer.sv
module tb_mii_rx_framer;
  localparam int CLK_P = 10;
  localparam int NV    = 6;
  localparam int V_PRE   [NV] = '{7, 1, 3, 15, 1, 2};
  localparam int V_NB    [NV] = '{64, 63, 1518, 1519, 70, 10};
  localparam int V_ODD   [NV] = '{0, 0, 0, 0, 1, 0};
  localparam int V_ER    [NV] = '{-1, -1, -1, -1, -1, 4};
  localparam int V_RUNT  [NV] = '{0, 1, 0, 0, 0, 1};
  localparam int V_LONG  [NV] = '{0, 0, 0, 1, 0, 0};

  logic clk = 0, rst_n = 0;
  logic [3:0] rxd = 0;
  logic dv = 0, er = 0;
  logic [7:0] byte_o;
  logic byte_valid, byte_sof, byte_err, eof;
  logic [10:0] len;
  logic runt, lng, align, serr, drop;

  int checks = 0, fails = 0;
  bit done = 0;

  mii_rx_framer dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .rx_dv_i(dv), .rx_er_i(er),
    .byte_o(byte_o), .byte_valid_o(byte_valid), .byte_sof_o(byte_sof),
    .byte_err_o(byte_err), .eof_o(eof), .stat_len_o(len),
    .stat_runt_o(runt), .stat_long_o(lng), .stat_align_o(align),
    .stat_err_o(serr), .stat_drop_o(drop)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitor
  int cyc = 0, nbytes = 0, mis = 0, sof_bad = 0, consec = 0, err_bytes = 0;
  int last_byte_cyc = 0, stat_cyc = 0, n_eof = 0;
  logic [7:0] seed = 0;
  logic prev_valid = 0;
  logic [10:0] c_len;
  logic c_runt, c_long, c_align, c_err, c_drop;

  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    if (byte_valid) begin
      if (byte_o != 8'(seed + nbytes)) mis++;
      if (byte_sof != (nbytes == 0)) sof_bad++;
      if (prev_valid) consec++;
      if (byte_err) err_bytes++;
      nbytes++;
      last_byte_cyc = cyc;
    end
    if (eof) begin
      n_eof++;
      stat_cyc = cyc;
      if (byte_valid) consec++;
      c_len = len; c_runt = runt; c_long = lng; c_align = align;
      c_err = serr; c_drop = drop;
    end
    prev_valid = byte_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nib(input logic [3:0] d, input logic v, input logic e);
    @(negedge clk);
    rxd = d; dv = v; er = e;
  endtask

  task automatic clear_mon(input logic [7:0] s);
    seed = s; nbytes = 0; mis = 0; sof_bad = 0; consec = 0; err_bytes = 0; n_eof = 0;
  endtask

  task automatic finish_burst;
    nib(4'h0, 0, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int pre, input int nb, input int odd, input int er_at,
                            input logic [7:0] s);
    clear_mon(s);
    for (int i = 0; i < pre; i++) nib(4'h5, 1, 0);
    nib(4'hD, 1, 0);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] v;
      v = 8'(s + b);
      nib(v[3:0], 1, (b == er_at));
      nib(v[7:4], 1, 0);
    end
    if (odd != 0) nib(4'h3, 1, 0);
    finish_burst();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!byte_valid && !byte_sof && !byte_err && !eof, "R1 outputs in reset",
        {byte_valid, byte_sof, byte_err, eof}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!byte_valid && !eof, "R1 outputs idle after reset", {byte_valid, eof}, 0);

    for (int k = 0; k < NV; k++) begin
      send_frame(V_PRE[k], V_NB[k], V_ODD[k], V_ER[k], 8'(17 * k + 3));
      chk(n_eof == 1, "R7 one end pulse", n_eof, 1);
      chk(nbytes == V_NB[k], "R2 byte count", nbytes, V_NB[k]);
      chk(mis == 0, "R2 byte values", mis, 0);
      chk(sof_bad == 0, "R6 start flag", sof_bad, 0);
      chk(consec == 0, "R2 byte spacing", consec, 0);
      chk(int'(c_len) == V_NB[k], "R7 stat length", c_len, V_NB[k]);
      chk(c_drop == 0, V_PRE[k] == 1 ? "R3 bare delimiter accepted" : "R3 accepted",
          c_drop, 0);
      chk(c_runt == V_RUNT[k][0], "R8 runt flag", c_runt, V_RUNT[k]);
      chk(c_long == V_LONG[k][0], "R9 oversize flag", c_long, V_LONG[k]);
      chk(c_align == V_ODD[k][0], "R10 alignment flag", c_align, V_ODD[k]);
      chk(c_err == (V_ER[k] >= 0), "R11 error status", c_err, V_ER[k] >= 0);
      if (V_ER[k] >= 0)
        chk(err_bytes == V_NB[k] - V_ER[k], "R11 byte error flag", err_bytes,
            V_NB[k] - V_ER[k]);
      if (V_ODD[k] == 0)
        chk(stat_cyc == last_byte_cyc + 1, "R7 end pulse timing",
            stat_cyc - last_byte_cyc, 1);
    end

    // R4: wrong preamble nibble, R5: later delimiter ignored
    clear_mon(8'h40);
    nib(4'h5, 1, 0); nib(4'h5, 1, 0); nib(4'h7, 1, 0); nib(4'h5, 1, 0); nib(4'hD, 1, 0);
    for (int i = 0; i < 16; i++) nib(4'(i), 1, 0);
    finish_burst();
    chk(nbytes == 0, "R5 no bytes after drop", nbytes, 0);
    chk(c_drop == 1 && c_len == 0, "R4 dropped status", {c_drop, c_len}, 1 << 11);

    // R4: delimiter as first nibble
    clear_mon(8'h00);
    nib(4'hD, 1, 0);
    for (int i = 0; i < 8; i++) nib(4'hA, 1, 0);
    finish_burst();
    chk(nbytes == 0 && c_drop == 1, "R4 leading delimiter nibble", c_drop, 1);

    // R12: burst ends in preamble
    clear_mon(8'h00);
    nib(4'h5, 1, 0); nib(4'h5, 1, 0); nib(4'h5, 1, 0);
    finish_burst();
    chk(n_eof == 1 && c_drop == 1 && c_len == 0, "R12 truncated preamble", c_drop, 1);

    // R3: shortest accepted burst, delimiter then two bytes
    send_frame(1, 2, 0, -1, 8'hF0);
    chk(c_drop == 0 && nbytes == 2 && c_runt == 1, "R3 minimal frame", nbytes, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule